// File: doc/BRIEF.md
# Transmit Loopback and Overrun Guard

This block watches a serial data-bus terminal while it drives the bus. Each word handed to the encoder is placed in a short queue of outstanding words. When the terminal's own decoder delivers the word it heard back from the bus, the guard compares the two. The read-back word must match exactly and must carry no parity or Manchester flag. If it does not, the guard aborts the transfer, raises a one-cycle failure interrupt and sets a sticky message-error flag. The surrounding logic uses that flag to withhold the status word and any words still to be sent.

A second, independent timer watches the transmitter enable. It does not depend on the encoder's own sequencing. If the enable stays high for longer than a parameterised number of clock cycles, the guard latches a transmitter-inhibit output and raises the failure interrupt. The inhibit stays set until `clear_i` or reset. The nominal limit is 668 µs expressed in clock cycles, and a bench may shorten it.

Top module: `tx_loopback_guard`

## Requirements
- R1: A read-back word equal to the oldest outstanding sent word, with `rx_par_err_i` and `rx_man_err_i` both low, retires that word and raises no failure output.
- R2: A read-back word that differs from the oldest outstanding word, or that arrives with a parity or Manchester flag, causes one failure. A failure makes `tx_abort_o` and `msg_fail_irq_o` high for exactly the cycle after the offending inputs were sampled, and sets `msg_err_o` from that cycle on.
- R3: A read-back word that arrives while no sent word is outstanding is a failure.
- R4: The oldest outstanding word becomes the head either when it is pushed into an empty queue or when the word ahead of it retires. If the head's read-back arrives k cycles later with k ≤ `ECHO_TMO`, it is on time. When k = `ECHO_TMO`+1 is reached without a read-back, that is a failure.
- R5: Up to `QDEPTH` words may be outstanding, and a read-back that retires a word in the same cycle frees a slot for a push. A push that would exceed `QDEPTH` is a failure.
- R6: After a failure, `msg_err_o` stays high and the outstanding words are discarded. Further pushes and read-backs raise no failure output until `clear_i`.
- R7: When `tx_en_i` is sampled high on `OVR_CYC`+1 consecutive cycles, `tx_inhibit_o` rises after the last of those samples, together with one `msg_fail_irq_o` pulse. Exactly `OVR_CYC` consecutive high samples do not trip the timer.
- R8: The duration count restarts whenever `tx_en_i` is sampled low. Bursts shorter than the limit never trip, whatever their total length.
- R9: Once set, `tx_inhibit_o` stays high regardless of `tx_en_i` until `clear_i` is sampled high.
- R10: `clear_i` clears `msg_err_o`, `tx_inhibit_o`, the queue and both timers. It takes priority over any fault present in the same cycle.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Clears the error flag, the inhibit, the queue and the timers |
| tx_en_i | input | 1 | Transmitter enable as driven to the line driver |
| tx_push_i | input | 1 | A word is handed to the encoder this cycle |
| tx_word_i | input | WORD_W | Word handed to the encoder |
| rx_valid_i | input | 1 | Decoder delivers a read-back word this cycle |
| rx_word_i | input | WORD_W | Read-back word |
| rx_par_err_i | input | 1 | Decoder saw a parity error on the read-back word |
| rx_man_err_i | input | 1 | Decoder saw a Manchester error on the read-back word |
| tx_abort_o | output | 1 | One-cycle pulse: transfer aborted on a loopback failure |
| msg_fail_irq_o | output | 1 | One-cycle message-failure interrupt (loopback failure or overrun) |
| msg_err_o | output | 1 | Sticky message-error flag |
| tx_inhibit_o | output | 1 | Latched force-off for the transmitter |

## Verification
Every cycle, the assertions check the invariants. The error flag and the inhibit are sticky until clear. The abort pulse never lasts two cycles, and every abort comes with an interrupt. The queue never exceeds its depth. The inhibit rises only when the duration count stood at its limit, and it always arrives with an interrupt. Only the bench scenarios can show the cycle-exact boundaries: a read-back on the last permitted cycle against one cycle late, `OVR_CYC` against `OVR_CYC`+1 high samples, a push into a full queue with and without a same-cycle retire, and clear winning over a same-cycle fault.

// File: rtl/txg_pkg.sv
package txg_pkg;
    localparam int unsigned TXG_WORD_W   = 16;
    localparam int unsigned TXG_QDEPTH   = 2;
    localparam int unsigned TXG_ECHO_TMO = 40;
    localparam int unsigned TXG_OVR_CYC  = 83500; // 668 us at 125 MHz

    typedef struct packed {
        logic mismatch;
        logic stray;
        logic late;
        logic overfill;
    } echo_fault_t;
endpackage

// File: rtl/txg_echo_check.sv
module txg_echo_check
    import txg_pkg::*;
#(
    parameter int unsigned WORD_W   = TXG_WORD_W,
    parameter int unsigned QDEPTH   = TXG_QDEPTH,
    parameter int unsigned ECHO_TMO = TXG_ECHO_TMO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tx_push_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              rx_valid_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              rx_par_err_i,
    input  logic              rx_man_err_i,
    output logic              abort_o,
    output logic              err_o
);
    localparam int unsigned PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(QDEPTH + 1);
    localparam int unsigned AGE_W = $clog2(ECHO_TMO + 1);

    typedef struct packed {
        logic [QDEPTH-1:0][WORD_W-1:0] slot;
        logic [PTR_W-1:0]              wr;
        logic [PTR_W-1:0]              rd;
        logic [CNT_W-1:0]              cnt;
        logic [AGE_W-1:0]              age;
        logic                          err;
        logic                          abort;
    } echo_st_t;

    echo_st_t    s_d, s_q;
    echo_fault_t flt;
    logic        pop;
    logic        fail;
    logic [CNT_W-1:0] cnt_left;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.abort = 1'b0;
        pop       = rx_valid_i && (s_q.cnt != '0);
        cnt_left  = s_q.cnt - CNT_W'(pop);

        flt.mismatch = pop && ((s_q.slot[s_q.rd] != rx_word_i) || rx_par_err_i || rx_man_err_i);
        flt.stray    = rx_valid_i && (s_q.cnt == '0);
        flt.late     = (s_q.cnt != '0) && (s_q.age == AGE_W'(ECHO_TMO));
        flt.overfill = tx_push_i && (cnt_left == CNT_W'(QDEPTH));
        fail         = (|flt) && !s_q.err && !clear_i;

        if (clear_i || s_q.err || fail) begin
            s_d.wr    = '0;
            s_d.rd    = '0;
            s_d.cnt   = '0;
            s_d.age   = '0;
            s_d.err   = !clear_i && (s_q.err || fail);
            s_d.abort = fail;
        end else begin
            if (pop) begin
                s_d.rd = ptr_next(s_q.rd);
            end
            if (tx_push_i) begin
                s_d.slot[s_q.wr] = tx_word_i;
                s_d.wr           = ptr_next(s_q.wr);
            end
            s_d.cnt = cnt_left + CNT_W'(tx_push_i);
            if ((s_q.cnt == '0) || pop || (s_d.cnt == '0)) begin
                s_d.age = '0;
            end else begin
                s_d.age = s_q.age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign abort_o = s_q.abort;
    assign err_o   = s_q.err;

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err && !clear_i |=> s_q.err);
    p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.abort |=> !s_q.abort);
    p_abort_sets_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.abort |-> s_q.err);
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(QDEPTH));
    p_clear_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !s_q.err && (s_q.cnt == '0));
endmodule

// File: rtl/txg_overrun.sv
module txg_overrun
    import txg_pkg::*;
#(
    parameter int unsigned OVR_CYC = TXG_OVR_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tx_en_i,
    output logic inhibit_o,
    output logic trip_o
);
    localparam int unsigned RUN_W = $clog2(OVR_CYC + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             inh;
        logic             trip;
    } ovr_st_t;

    ovr_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.trip = 1'b0;
        if (clear_i) begin
            s_d.run = '0;
            s_d.inh = 1'b0;
        end else begin
            if (!tx_en_i) begin
                s_d.run = '0;
            end else if (s_q.run != RUN_W'(OVR_CYC)) begin
                s_d.run = s_q.run + 1'b1;
            end
            if (tx_en_i && (s_q.run == RUN_W'(OVR_CYC)) && !s_q.inh) begin
                s_d.inh  = 1'b1;
                s_d.trip = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign inhibit_o = s_q.inh;
    assign trip_o    = s_q.trip;

    p_inhibit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.inh && !clear_i |=> s_q.inh);
    p_inhibit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.inh) |-> $past(tx_en_i) && ($past(s_q.run) == RUN_W'(OVR_CYC)));
    p_low_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i && !s_q.inh |=> !s_q.inh);
    p_clear_inh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !s_q.inh && !s_q.trip);
endmodule

// File: rtl/tx_loopback_guard.sv
module tx_loopback_guard
    import txg_pkg::*;
#(
    parameter int unsigned WORD_W   = TXG_WORD_W,
    parameter int unsigned QDEPTH   = TXG_QDEPTH,
    parameter int unsigned ECHO_TMO = TXG_ECHO_TMO,
    parameter int unsigned OVR_CYC  = TXG_OVR_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tx_en_i,
    input  logic              tx_push_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              rx_valid_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              rx_par_err_i,
    input  logic              rx_man_err_i,
    output logic              tx_abort_o,
    output logic              msg_fail_irq_o,
    output logic              msg_err_o,
    output logic              tx_inhibit_o
);
    logic echo_abort;
    logic ovr_trip;

    txg_echo_check #(
        .WORD_W  (WORD_W),
        .QDEPTH  (QDEPTH),
        .ECHO_TMO(ECHO_TMO)
    ) u_echo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .tx_push_i   (tx_push_i),
        .tx_word_i   (tx_word_i),
        .rx_valid_i  (rx_valid_i),
        .rx_word_i   (rx_word_i),
        .rx_par_err_i(rx_par_err_i),
        .rx_man_err_i(rx_man_err_i),
        .abort_o     (echo_abort),
        .err_o       (msg_err_o)
    );

    txg_overrun #(
        .OVR_CYC(OVR_CYC)
    ) u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .tx_en_i  (tx_en_i),
        .inhibit_o(tx_inhibit_o),
        .trip_o   (ovr_trip)
    );

    assign tx_abort_o     = echo_abort;
    assign msg_fail_irq_o = echo_abort | ovr_trip;

    p_inhibit_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit_o) |-> msg_fail_irq_o);
    p_abort_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_err_o) |-> msg_fail_irq_o && tx_abort_o);
endmodule

// File: tb/tx_loopback_guard_test.sv
module tx_loopback_guard_test;
    localparam int W     = 16;
    localparam int DEPTH = 2;
    localparam int TMO   = 6;
    localparam int LIMIT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 0, tx_en_i = 0, tx_push_i = 0, rx_valid_i = 0;
    logic rx_par_err_i = 0, rx_man_err_i = 0;
    logic [W-1:0] tx_word_i = '0, rx_word_i = '0;
    logic tx_abort_o, msg_fail_irq_o, msg_err_o, tx_inhibit_o;

    int checks = 0;
    int fails  = 0;
    string phase = "R11";
    bit started = 0;

    always #4 clk = ~clk;

    tx_loopback_guard #(.WORD_W(W), .QDEPTH(DEPTH), .ECHO_TMO(TMO), .OVR_CYC(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .tx_en_i(tx_en_i),
        .tx_push_i(tx_push_i), .tx_word_i(tx_word_i), .rx_valid_i(rx_valid_i),
        .rx_word_i(rx_word_i), .rx_par_err_i(rx_par_err_i), .rx_man_err_i(rx_man_err_i),
        .tx_abort_o(tx_abort_o), .msg_fail_irq_o(msg_fail_irq_o),
        .msg_err_o(msg_err_o), .tx_inhibit_o(tx_inhibit_o)
    );

    // behavioural reference model
    logic [W-1:0] mq[$];
    int  age = 0, run = 0;
    bit  m_err = 0, m_inh = 0, m_abort = 0, m_trip = 0;

    always @(posedge clk) begin
        int  sz;
        bit  fail, popped;
        logic [W-1:0] exp_w;
        started = 1;
        m_abort = 0; m_trip = 0;
        if (!rst_n) begin
            mq.delete(); age = 0; run = 0; m_err = 0; m_inh = 0;
        end else if (clear_i) begin
            mq.delete(); age = 0; run = 0; m_err = 0; m_inh = 0;
        end else begin
            if (tx_en_i) begin
                run++;
                if (run == LIMIT + 1 && !m_inh) begin m_inh = 1; m_trip = 1; end
            end else run = 0;
            if (!m_err) begin
                sz = mq.size(); fail = 0; popped = 0;
                if (sz > 0 && age == TMO) fail = 1;
                if (rx_valid_i) begin
                    if (sz == 0) fail = 1;
                    else begin
                        exp_w = mq.pop_front(); popped = 1;
                        if (exp_w != rx_word_i || rx_par_err_i || rx_man_err_i) fail = 1;
                    end
                end
                if (tx_push_i) begin
                    if (mq.size() == DEPTH) fail = 1;
                    else mq.push_back(tx_word_i);
                end
                if (fail) begin
                    mq.delete(); age = 0; m_err = 1; m_abort = 1;
                end else if (sz == 0 || popped || mq.size() == 0) age = 0;
                else age++;
            end
        end
    end

    task automatic cmp(input string tag, input logic act, input logic exp_v, input string what);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            cmp(phase, tx_inhibit_o, m_inh, "tx_inhibit_o");
            cmp(phase, tx_abort_o, m_abort, "tx_abort_o");
            cmp(phase, msg_fail_irq_o, m_abort | m_trip, "msg_fail_irq_o");
            cmp(phase, msg_err_o, m_err, "msg_err_o");
        end
    end

    task automatic cyc(input bit push, input logic [W-1:0] tw, input bit rv,
                       input logic [W-1:0] rw, input bit pe, input bit me, input bit clr);
        tx_push_i = push; tx_word_i = tw; rx_valid_i = rv; rx_word_i = rw;
        rx_par_err_i = pe; rx_man_err_i = me; clear_i = clr;
        @(negedge clk);
        tx_push_i = 0; rx_valid_i = 0; rx_par_err_i = 0; rx_man_err_i = 0; clear_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, 0, 0);
    endtask

    task automatic push(input logic [W-1:0] w); cyc(1, w, 0, '0, 0, 0, 0); endtask
    task automatic echo(input logic [W-1:0] w); cyc(0, '0, 1, w, 0, 0, 0); endtask
    task automatic do_clear(); cyc(0, '0, 0, '0, 0, 0, 1); endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        phase = "R11";
        cmp("R11", tx_abort_o | msg_fail_irq_o | msg_err_o | tx_inhibit_o, 1'b0, "outputs in reset");
        rst_n = 1;
        @(negedge clk);
        cmp("R11", msg_err_o | tx_inhibit_o, 1'b0, "outputs after reset");

        phase = "R1";
        push(16'hA5A5); idle(1); echo(16'hA5A5);
        push(16'h1111); push(16'h2222);
        cyc(1, 16'h3333, 1, 16'h1111, 0, 0, 0);
        echo(16'h2222); echo(16'h3333); idle(2);
        cmp("R1", msg_err_o, 1'b0, "clean echoes leave no error");

        phase = "R2";
        push(16'h1234); echo(16'h1235);
        cmp("R2", tx_abort_o, 1'b1, "abort on mismatch");
        cmp("R2", msg_fail_irq_o, 1'b1, "irq on mismatch");
        idle(1);
        cmp("R2", tx_abort_o, 1'b0, "abort is one cycle");
        phase = "R6";
        push(16'h0001); echo(16'h7777); echo(16'h0002); idle(TMO + 3);
        cmp("R6", msg_err_o, 1'b1, "error stays set");
        cmp("R6", tx_abort_o, 1'b0, "no repeat abort");
        phase = "R10";
        do_clear();
        cmp("R10", msg_err_o, 1'b0, "clear drops error");

        phase = "R2";
        push(16'h0F0F); cyc(0, '0, 1, 16'h0F0F, 1, 0, 0);
        cmp("R2", tx_abort_o, 1'b1, "parity flag fails");
        do_clear();
        push(16'hF0F0); cyc(0, '0, 1, 16'hF0F0, 0, 1, 0);
        cmp("R2", tx_abort_o, 1'b1, "manchester flag fails");
        do_clear();

        phase = "R3";
        echo(16'h4444);
        cmp("R3", tx_abort_o, 1'b1, "stray read-back fails");
        do_clear();

        phase = "R4";
        push(16'h5555); idle(TMO - 1); echo(16'h5555);
        cmp("R4", tx_abort_o, 1'b0, "echo on last allowed cycle");
        push(16'h6666); idle(TMO);
        cmp("R4", tx_abort_o, 1'b0, "not yet late");
        echo(16'h6666);
        cmp("R4", tx_abort_o, 1'b1, "one cycle late fails");
        do_clear();

        phase = "R5";
        push(16'h0A0A); push(16'h0B0B);
        cyc(1, 16'h0C0C, 1, 16'h0A0A, 0, 0, 0);
        cmp("R5", tx_abort_o, 1'b0, "push with retire when full");
        echo(16'h0B0B); echo(16'h0C0C);
        push(16'h0101); push(16'h0202); push(16'h0303);
        cmp("R5", tx_abort_o, 1'b1, "push beyond depth fails");
        do_clear();

        phase = "R10";
        push(16'h0909); cyc(0, '0, 1, 16'h9999, 0, 0, 1);
        cmp("R10", msg_err_o, 1'b0, "clear beats mismatch");
        idle(TMO + 3);
        cmp("R10", msg_err_o, 1'b0, "queue flushed by clear");

        phase = "R7";
        tx_en_i = 1; idle(LIMIT); tx_en_i = 0; idle(1);
        cmp("R7", tx_inhibit_o, 1'b0, "exact limit does not trip");
        tx_en_i = 1; idle(LIMIT);
        cmp("R7", tx_inhibit_o, 1'b0, "still under limit");
        idle(1);
        cmp("R7", tx_inhibit_o, 1'b1, "trips after limit+1");
        cmp("R7", msg_fail_irq_o, 1'b1, "irq on overrun");
        phase = "R9";
        idle(3); tx_en_i = 0; idle(5);
        cmp("R9", tx_inhibit_o, 1'b1, "inhibit held with enable low");
        phase = "R10";
        do_clear();
        cmp("R10", tx_inhibit_o, 1'b0, "clear drops inhibit");

        phase = "R8";
        for (int b = 0; b < 4; b++) begin
            tx_en_i = 1; idle(LIMIT - 5); tx_en_i = 0; idle(1);
        end
        cmp("R8", tx_inhibit_o, 1'b0, "short bursts never trip");

        phase = "R10";
        tx_en_i = 1; idle(LIMIT); cyc(0, '0, 0, '0, 0, 0, 1);
        cmp("R10", tx_inhibit_o, 1'b0, "clear beats trip");
        tx_en_i = 0; idle(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule